// File: doc/BRIEF.md
# Index-Port Calendar Clock with Scratch RAM

This block is a calendar clock plus general-purpose byte storage. A host reaches it through a small window of byte ports. The ports are grouped into banks of two. For each bank, the host writes the location it wants into the bank's index port. It then reads or writes the bank's data port, and the access lands on the location most recently selected. Bank 0 holds the time and calendar fields and four control locations. Every other location in bank 0, and every location in the other banks, is plain storage.

A one-second strobe (`sec_tick`) starts an update window. Control location A shows a busy flag during this window. The flag rises a fixed number of cycles before the time fields advance and stays up for a few cycles after they advance. Software that sees the flag clear can then read a consistent time. Control location B selects BCD or binary coding and 12-hour or 24-hour hours. It also carries an inhibit bit. While the inhibit bit is set, the clock does not advance, so software can load a new time. Time is kept internally in binary 24-hour form, and it is coded into the selected form on every access.

The host request side is valid/ready. A request is accepted on a clock edge where both `bus_req_valid` and `bus_req_ready` are high. The host must hold the port, direction and write data stable until the request is accepted. The block drops ready for exactly one cycle per update window: the cycle in which the time fields advance. A read returns on `rsp_valid`/`rsp_data` one cycle after it is accepted. The response has no back-pressure, so the host must take it in that cycle.

Top module: `idxclk_top`

## Requirements
- R1: Bank N has its index port at port 2N and its data port at port 2N+1. An accepted read raises `rsp_valid` for one cycle, on the edge after acceptance. Ports at or above 2·NUM_BANKS read as 0xFF, and writes to them change nothing.
- R2: Each bank keeps its own index register. A data-port access acts on the location most recently written to that bank's index port. A read of an index port returns the selected location with bit 7 clear.
- R3: Bank 0 locations 0x0E and up, every location of the other banks, and bank 0 locations 0x01, 0x03, 0x05 and 0x06 all read back the last byte written to them.
- R4: The time fields are at these bank 0 locations: seconds 0x00, minutes 0x02, hours 0x04, day 0x07, month 0x08, year 0x09. Control bit B[2] selects the coding: set means binary, clear means packed BCD. The coding applies to both reads and writes.
- R5: Control bit B[1] selects the hour form: set means 24-hour, clear means 12-hour. In 12-hour form, hours bit 7 is the PM flag and the hour is 1–12. Midnight is 12 with PM clear (0x12 in BCD), and noon is 12 with PM set (0x92 in BCD).
- R6: A `sec_tick` pulse that arrives while no window is open starts a window. Bit A[7] reads 1 for UIP_LEAD cycles, then the fields advance, then A[7] stays 1 for UIP_TAIL more cycles. The time fields do not change while A[7] is 0, except by host writes. A tick that arrives during an open window is ignored.
- R7: Each update adds one second. Seconds carry into minutes at 59, minutes carry into hours at 59, and hours carry into day at 23.
- R8: The day rolls over after the last day of its month: 30 days for months 4, 6, 9 and 11; 29 days for month 2 when the year is divisible by 4, otherwise 28; 31 days for all other months. Month 12 rolls over to 1 and increments the year. Year 99 rolls over to 0.
- R9: While inhibit bit B[7] is set, ticks open no window and the time does not advance. After B[7] is cleared, ticks advance the time again.
- R10: `bus_req_ready` is low for exactly one cycle per update window, and high at all other times.
- R11: Bits A[6:0] read back what was written to them, and A[7] cannot be written. Location C always reads 0x00 and location D always reads 0x80. Writes to C and D are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| bus_req_valid | input | 1 | Host request valid |
| bus_req_ready | output | 1 | Block accepts the request this cycle |
| bus_req_write | input | 1 | 1 = write, 0 = read |
| bus_req_port | input | PORT_W | Port offset |
| bus_req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read data valid, one cycle after acceptance |
| rsp_data | output | 8 | Read byte |

## Verification
The hardest condition to reach from the ports is a read that lands inside the update window, before the fields advance. The bench raises the window to 16 leading cycles and selects control location A ahead of time, so that a single data read right after the tick sees the busy flag. One index write and one read of seconds then show the old value. A full year rollover needs the clock to be at 23:59:59 on 31 December 99. The bench reaches that state by setting the inhibit bit, loading every field, and clearing the bit before the tick. It reaches the leap and non-leap February edges, and the 12-hour midnight and noon crossings, the same way. The single stall cycle is found by sampling `bus_req_ready` on every cycle of a window.

// File: rtl/idxclk_pkg.sv
package idxclk_pkg;
  localparam logic [6:0] LOC_SEC  = 7'h00;
  localparam logic [6:0] LOC_MIN  = 7'h02;
  localparam logic [6:0] LOC_HOUR = 7'h04;
  localparam logic [6:0] LOC_DAY  = 7'h07;
  localparam logic [6:0] LOC_MON  = 7'h08;
  localparam logic [6:0] LOC_YEAR = 7'h09;
  localparam logic [6:0] LOC_CA   = 7'h0A;
  localparam logic [6:0] LOC_CB   = 7'h0B;
  localparam logic [6:0] LOC_CC   = 7'h0C;
  localparam logic [6:0] LOC_CD   = 7'h0D;

  localparam int B_INHIBIT = 7;
  localparam int B_BINARY  = 2;
  localparam int B_H24     = 1;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] day;
    logic [7:0] mon;
    logic [7:0] year;
  } tod_t;

  typedef enum logic [2:0] {F_SEC, F_MIN, F_HOUR, F_DAY, F_MON, F_YEAR} fld_e;

  function automatic logic [7:0] to_bcd(input logic [7:0] x);
    logic [7:0] t, o;
    t = x / 8'd10;
    o = x % 8'd10;
    return {t[3:0], o[3:0]};
  endfunction

  function automatic logic [7:0] from_bcd(input logic [7:0] v);
    return {4'b0, v[7:4]} * 8'd10 + {4'b0, v[3:0]};
  endfunction

  function automatic logic [7:0] enc(input logic [7:0] x, input logic bin);
    return bin ? x : to_bcd(x);
  endfunction

  function automatic logic [7:0] dec(input logic [7:0] v, input logic bin);
    return bin ? v : from_bcd(v);
  endfunction

  function automatic logic [7:0] enc_hour(input logic [7:0] h, input logic bin, input logic h24);
    logic [7:0] h12, e;
    if (h24) return enc(h, bin);
    h12 = (h == 8'd0) ? 8'd12 : ((h > 8'd12) ? h - 8'd12 : h);
    e = enc(h12, bin);
    return {(h >= 8'd12), e[6:0]};
  endfunction

  function automatic logic [7:0] dec_hour(input logic [7:0] v, input logic bin, input logic h24);
    logic [7:0] h;
    if (h24) return dec(v, bin);
    h = dec({1'b0, v[6:0]}, bin);
    if (h == 8'd12) return v[7] ? 8'd12 : 8'd0;
    return v[7] ? h + 8'd12 : h;
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] year);
    case (mon)
      8'd2: return (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      default: return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/idxclk_port_dec.sv
module idxclk_port_dec #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_LOCS = 128,
  parameter int PORT_W    = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         acc,
  input  logic                         wr,
  input  logic [PORT_W-1:0]            port,
  input  logic [7:0]                   wdata,
  output logic                         in_range,
  output logic                         is_data,
  output logic [PORT_W-2:0]            bank,
  output logic [$clog2(BANK_LOCS)-1:0] cur_idx
);
  localparam int IDX_W = $clog2(BANK_LOCS);

  logic [NUM_BANKS-1:0][IDX_W-1:0] idx_q;

  assign in_range = (int'(port) < 2 * NUM_BANKS);
  assign is_data  = port[0];
  assign bank     = port[PORT_W-1:1];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idx_q[b] <= '0;
      else if (acc && wr && in_range && !is_data && int'(bank) == b)
        idx_q[b] <= wdata[IDX_W-1:0];
    end
  end

  always_comb begin
    cur_idx = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (int'(bank) == b) cur_idx = idx_q[b];
  end

  assert_index_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && wr && !is_data) |=> $stable(idx_q));
endmodule

// File: rtl/idxclk_timekeeper.sv
module idxclk_timekeeper
  import idxclk_pkg::*;
#(
  parameter int UIP_LEAD = 8,
  parameter int UIP_TAIL = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       inhibit,
  input  logic       wr_en,
  input  fld_e       wr_fld,
  input  logic [7:0] wr_val,
  output tod_t       tod,
  output logic       uip,
  output logic       commit
);
  localparam int MAXW  = (UIP_LEAD > UIP_TAIL) ? UIP_LEAD : UIP_TAIL;
  localparam int CNT_W = $clog2(MAXW + 1);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_TAIL} st_e;
  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;
  tod_t             tod_q, nxt;

  assign commit = (st_q == S_LEAD) && (cnt_q == '0);
  assign uip    = (st_q != S_IDLE);
  assign tod    = tod_q;

  always_comb begin
    nxt = tod_q;
    if (tod_q.sec >= 8'd59) begin
      nxt.sec = 8'd0;
      if (tod_q.min >= 8'd59) begin
        nxt.min = 8'd0;
        if (tod_q.hour >= 8'd23) begin
          nxt.hour = 8'd0;
          if (tod_q.day >= month_days(tod_q.mon, tod_q.year)) begin
            nxt.day = 8'd1;
            if (tod_q.mon >= 8'd12) begin
              nxt.mon  = 8'd1;
              nxt.year = (tod_q.year >= 8'd99) ? 8'd0 : tod_q.year + 8'd1;
            end else nxt.mon = tod_q.mon + 8'd1;
          end else nxt.day = tod_q.day + 8'd1;
        end else nxt.hour = tod_q.hour + 8'd1;
      end else nxt.min = tod_q.min + 8'd1;
    end else nxt.sec = tod_q.sec + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (tick && !inhibit) begin
          st_q  <= S_LEAD;
          cnt_q <= CNT_W'(UIP_LEAD - 1);
        end
        S_LEAD: if (cnt_q == '0) begin
          st_q  <= S_TAIL;
          cnt_q <= CNT_W'(UIP_TAIL - 1);
        end else cnt_q <= cnt_q - 1'b1;
        default: if (cnt_q == '0) st_q <= S_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tod_q <= '{sec: 8'd0, min: 8'd0, hour: 8'd0, day: 8'd1, mon: 8'd1, year: 8'd0};
    end else if (wr_en) begin
      case (wr_fld)
        F_SEC:   tod_q.sec  <= wr_val;
        F_MIN:   tod_q.min  <= wr_val;
        F_HOUR:  tod_q.hour <= wr_val;
        F_DAY:   tod_q.day  <= wr_val;
        F_MON:   tod_q.mon  <= wr_val;
        default: tod_q.year <= wr_val;
      endcase
    end else if (commit && !inhibit) begin
      tod_q <= nxt;
    end
  end

  assert_quiet_outside_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!uip && !wr_en) |=> $stable(tod_q));
  assert_commit_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(uip));
  assert_inhibit_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !wr_en) |=> $stable(tod_q));
endmodule

// File: rtl/idxclk_nvram.sv
module idxclk_nvram #(
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [7:0]               wdata,
  output logic [7:0]               rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/idxclk_top.sv
module idxclk_top
  import idxclk_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_LOCS = 128,
  parameter int PORT_W    = 3,
  parameter int UIP_LEAD  = 8,
  parameter int UIP_TAIL  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              bus_req_valid,
  output logic              bus_req_ready,
  input  logic              bus_req_write,
  input  logic [PORT_W-1:0] bus_req_port,
  input  logic [7:0]        bus_req_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data
);
  localparam int IDX_W  = $clog2(BANK_LOCS);
  localparam int DEPTH  = NUM_BANKS * BANK_LOCS;
  localparam int ADDR_W = $clog2(DEPTH);

  logic              acc, in_range, is_data, data_wr, bank0, clk_loc, tim_loc;
  logic [PORT_W-2:0] bank;
  logic [IDX_W-1:0]  cur_idx;
  logic [6:0]        loc;
  logic [6:0]        a_low_q;
  logic [7:0]        b_q, ram_rd, rd_mux, tk_val;
  logic [ADDR_W-1:0] ram_addr;
  logic              uip, commit, tk_we;
  fld_e              tk_fld;
  tod_t              tod;
  logic              bin, h24;

  assign acc = bus_req_valid && bus_req_ready;
  assign bus_req_ready = !commit;
  assign bin = b_q[B_BINARY];
  assign h24 = b_q[B_H24];

  idxclk_port_dec #(.NUM_BANKS(NUM_BANKS), .BANK_LOCS(BANK_LOCS), .PORT_W(PORT_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .acc(acc), .wr(bus_req_write), .port(bus_req_port),
    .wdata(bus_req_wdata), .in_range(in_range), .is_data(is_data), .bank(bank),
    .cur_idx(cur_idx)
  );

  assign loc     = 7'(cur_idx);
  assign bank0   = (bank == '0);
  assign data_wr = acc && bus_req_write && in_range && is_data;

  always_comb begin
    tim_loc = 1'b1;
    tk_fld  = F_SEC;
    case (loc)
      LOC_SEC:  tk_fld = F_SEC;
      LOC_MIN:  tk_fld = F_MIN;
      LOC_HOUR: tk_fld = F_HOUR;
      LOC_DAY:  tk_fld = F_DAY;
      LOC_MON:  tk_fld = F_MON;
      LOC_YEAR: tk_fld = F_YEAR;
      default:  tim_loc = 1'b0;
    endcase
    tim_loc = tim_loc && bank0;
    clk_loc = tim_loc || (bank0 && loc >= LOC_CA && loc <= LOC_CD);
  end

  assign tk_we  = data_wr && tim_loc;
  assign tk_val = (tk_fld == F_HOUR) ? dec_hour(bus_req_wdata, bin, h24)
                                     : dec(bus_req_wdata, bin);

  idxclk_timekeeper #(.UIP_LEAD(UIP_LEAD), .UIP_TAIL(UIP_TAIL)) u_tk (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .inhibit(b_q[B_INHIBIT]),
    .wr_en(tk_we), .wr_fld(tk_fld), .wr_val(tk_val), .tod(tod), .uip(uip), .commit(commit)
  );

  assign ram_addr = ADDR_W'(int'(bank) * BANK_LOCS + int'(cur_idx));

  idxclk_nvram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(data_wr && !clk_loc), .addr(ram_addr), .wdata(bus_req_wdata),
    .rdata(ram_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_low_q <= '0;
      b_q     <= 8'h02;
    end else if (data_wr && bank0) begin
      if (loc == LOC_CA) a_low_q <= bus_req_wdata[6:0];
      if (loc == LOC_CB) b_q     <= bus_req_wdata;
    end
  end

  always_comb begin
    if (!in_range)     rd_mux = 8'hFF;
    else if (!is_data) rd_mux = {1'b0, loc};
    else if (!clk_loc) rd_mux = ram_rd;
    else begin
      case (loc)
        LOC_SEC:  rd_mux = enc(tod.sec, bin);
        LOC_MIN:  rd_mux = enc(tod.min, bin);
        LOC_HOUR: rd_mux = enc_hour(tod.hour, bin, h24);
        LOC_DAY:  rd_mux = enc(tod.day, bin);
        LOC_MON:  rd_mux = enc(tod.mon, bin);
        LOC_YEAR: rd_mux = enc(tod.year, bin);
        LOC_CA:   rd_mux = {uip, a_low_q};
        LOC_CB:   rd_mux = b_q;
        LOC_CC:   rd_mux = 8'h00;
        default:  rd_mux = 8'h80;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= acc && !bus_req_write;
      if (acc && !bus_req_write) rsp_data <= rd_mux;
    end
  end

  assert_rsp_follows_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_ready && !bus_req_write) |=> rsp_valid);
  assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req_valid || bus_req_write) |=> !rsp_valid);
  assert_single_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req_ready |=> bus_req_ready);
endmodule

// File: tb/tb_idxclk_top.sv
module tb_idxclk_top;
  localparam int PW = 3;
  localparam int LEAD = 16;
  localparam int TAIL = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic vld = 1'b0, rdy, wr = 1'b0, rv;
  logic [PW-1:0] port = '0;
  logic [7:0] wd = '0, rd;
  int vectors = 0, errors = 0;

  always #2 clk = ~clk;

  idxclk_top #(.PORT_W(PW), .UIP_LEAD(LEAD), .UIP_TAIL(TAIL)) dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(tick), .bus_req_valid(vld), .bus_req_ready(rdy),
    .bus_req_write(wr), .bus_req_port(port), .bus_req_wdata(wd), .rsp_valid(rv), .rsp_data(rd)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [PW-1:0] p, input logic [7:0] d,
                      output logic [7:0] q);
    @(negedge clk);
    vld = 1'b1; wr = w; port = p; wd = d;
    while (!rdy) @(negedge clk);
    @(negedge clk);
    vld = 1'b0;
    q = rd;
    if (!w) check("R1 rsp_valid", {7'b0, rv}, 8'h01);
  endtask

  task automatic wreg(input int b, input logic [7:0] idx, input logic [7:0] d);
    logic [7:0] q;
    xfer(1'b1, PW'(2 * b), idx, q);
    xfer(1'b1, PW'(2 * b + 1), d, q);
  endtask

  task automatic rreg(input int b, input logic [7:0] idx, output logic [7:0] q);
    logic [7:0] t;
    xfer(1'b1, PW'(2 * b), idx, t);
    xfer(1'b0, PW'(2 * b + 1), 8'h00, q);
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] q;
    for (int i = 0; i < 100; i++) begin
      rreg(0, 8'h0A, q);
      if (!q[7]) break;
    end
  endtask

  task automatic load(input logic [7:0] mode, input logic [7:0] s, input logic [7:0] m,
                      input logic [7:0] h, input logic [7:0] d, input logic [7:0] mo,
                      input logic [7:0] y);
    wreg(0, 8'h0B, mode | 8'h80);
    wreg(0, 8'h00, s); wreg(0, 8'h02, m); wreg(0, 8'h04, h);
    wreg(0, 8'h07, d); wreg(0, 8'h08, mo); wreg(0, 8'h09, y);
    wreg(0, 8'h0B, mode);
  endtask

  task automatic t_reset();
    logic [7:0] q;
    rreg(0, 8'h0B, q); check("R4 reset B", q, 8'h02);
    rreg(0, 8'h0C, q); check("R11 reset C", q, 8'h00);
    rreg(0, 8'h0D, q); check("R11 reset D", q, 8'h80);
    rreg(0, 8'h07, q); check("R4 reset day", q, 8'h01);
  endtask

  task automatic t_ports();
    logic [7:0] q;
    wreg(1, 8'h10, 8'hA5);
    wreg(0, 8'h10, 8'h5A);
    wreg(0, 8'h03, 8'h3C);
    rreg(1, 8'h10, q); check("R3 bank1 ram", q, 8'hA5);
    rreg(0, 8'h10, q); check("R3 bank0 ram", q, 8'h5A);
    rreg(0, 8'h03, q); check("R3 spare loc", q, 8'h3C);
    wreg(1, 8'h00, 8'h77);
    rreg(1, 8'h00, q); check("R3 bank1 loc0", q, 8'h77);
    xfer(1'b1, 3'd2, 8'h10, q);
    xfer(1'b0, 3'd3, 8'h00, q); check("R2 bank1 keeps index", q, 8'hA5);
    xfer(1'b0, 3'd2, 8'h00, q); check("R2 index readback", q, 8'h10);
    xfer(1'b1, 3'd0, 8'h8B, q);
    xfer(1'b0, 3'd0, 8'h00, q); check("R2 index bit7 clear", q, 8'h0B);
    xfer(1'b1, 3'd5, 8'h33, q);
    xfer(1'b0, 3'd5, 8'h00, q); check("R1 out of range", q, 8'hFF);
    xfer(1'b0, 3'd0, 8'h00, q); check("R1 ignored write", q, 8'h0B);
  endtask

  task automatic t_ctrl();
    logic [7:0] q;
    wreg(0, 8'h0A, 8'hFF); rreg(0, 8'h0A, q); check("R11 A low bits", q, 8'h7F);
    wreg(0, 8'h0A, 8'h00);
    wreg(0, 8'h0C, 8'h55); rreg(0, 8'h0C, q); check("R11 C ignored", q, 8'h00);
    wreg(0, 8'h0D, 8'h11); rreg(0, 8'h0D, q); check("R11 D ignored", q, 8'h80);
  endtask

  task automatic t_bcd_rollover();
    logic [7:0] q, t;
    load(8'h02, 8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99);
    xfer(1'b1, 3'd0, 8'h0A, t);
    pulse();
    xfer(1'b0, 3'd1, 8'h00, q); check("R6 busy after tick", q & 8'h80, 8'h80);
    rreg(0, 8'h00, q); check("R6 old value in lead", q, 8'h59);
    wait_idle();
    rreg(0, 8'h00, q); check("R7 sec wrap", q, 8'h00);
    rreg(0, 8'h02, q); check("R7 min wrap", q, 8'h00);
    rreg(0, 8'h04, q); check("R7 hour wrap", q, 8'h00);
    rreg(0, 8'h07, q); check("R8 day wrap", q, 8'h01);
    rreg(0, 8'h08, q); check("R8 month wrap", q, 8'h01);
    rreg(0, 8'h09, q); check("R8 year wrap", q, 8'h00);
  endtask

  task automatic t_binary_months();
    logic [7:0] q;
    load(8'h06, 8'd59, 8'd59, 8'd23, 8'd28, 8'd2, 8'd24);
    pulse(); wait_idle();
    rreg(0, 8'h07, q); check("R8 leap feb day", q, 8'd29);
    rreg(0, 8'h08, q); check("R4 binary month", q, 8'd2);
    load(8'h06, 8'd59, 8'd59, 8'd23, 8'd28, 8'd2, 8'd23);
    pulse(); wait_idle();
    rreg(0, 8'h07, q); check("R8 feb end", q, 8'd1);
    rreg(0, 8'h08, q); check("R8 march", q, 8'd3);
    load(8'h06, 8'd59, 8'd59, 8'd23, 8'd30, 8'd4, 8'd23);
    pulse(); wait_idle();
    rreg(0, 8'h08, q); check("R8 april end", q, 8'd5);
    load(8'h06, 8'd58, 8'd30, 8'd10, 8'd30, 8'd5, 8'd23);
    pulse(); wait_idle();
    rreg(0, 8'h00, q); check("R4 binary sec", q, 8'd59);
    rreg(0, 8'h07, q); check("R8 may 30 kept", q, 8'd30);
  endtask

  task automatic t_12h();
    logic [7:0] q;
    load(8'h00, 8'h59, 8'h59, 8'h91, 8'h10, 8'h05, 8'h21);
    pulse(); wait_idle();
    rreg(0, 8'h04, q); check("R5 midnight 12h", q, 8'h12);
    rreg(0, 8'h07, q); check("R7 day carry", q, 8'h11);
    wreg(0, 8'h0B, 8'h02);
    rreg(0, 8'h04, q); check("R5 midnight 24h", q, 8'h00);
    load(8'h00, 8'h59, 8'h59, 8'h11, 8'h10, 8'h05, 8'h21);
    pulse(); wait_idle();
    rreg(0, 8'h04, q); check("R5 noon 12h", q, 8'h92);
    wreg(0, 8'h0B, 8'h02);
    rreg(0, 8'h04, q); check("R5 noon 24h", q, 8'h12);
  endtask

  task automatic t_inhibit();
    logic [7:0] q;
    load(8'h02, 8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
    wreg(0, 8'h0B, 8'h82);
    pulse();
    rreg(0, 8'h0A, q); check("R9 no window", q & 8'h80, 8'h00);
    repeat (LEAD + TAIL + 4) @(negedge clk);
    rreg(0, 8'h00, q); check("R9 frozen", q, 8'h10);
    wreg(0, 8'h0B, 8'h02);
    pulse(); wait_idle();
    rreg(0, 8'h00, q); check("R9 resumes", q, 8'h11);
  endtask

  task automatic t_stall_and_retick();
    logic [7:0] q;
    int lows;
    lows = 0;
    load(8'h02, 8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
    pulse();
    for (int i = 0; i < LEAD + TAIL + 4; i++) begin
      if (!rdy) lows++;
      if (i == 3) tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
    check("R10 one stall cycle", 8'(lows), 8'd1);
    wait_idle();
    rreg(0, 8'h00, q); check("R6 retick ignored", q, 8'h21);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    check("R1 rsp idle after reset", {7'b0, rv}, 8'h00);
    check("R10 ready after reset", {7'b0, rdy}, 8'h01);
    t_reset();
    t_ports();
    t_ctrl();
    t_bcd_rollover();
    t_binary_months();
    t_12h();
    t_inhibit();
    t_stall_and_retick();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule